// File: doc/BRIEF.md
# Receive Word Queue with Error Tracking

This block is the receive-side word store of a 16550-style serial port. A deserializer hands it one received character at a time, with parity, framing and break indications. The block keeps up to sixteen such characters in arrival order, or exactly one when queueing is switched off. It presents the oldest character, masked to the configured character length, together with that character's own error flags. It also produces a data-present bit, an overrun bit, a summary bit that is set while any stored character carries an error, a trigger request, and a character-timeout request.

Configuration comes from the surrounding register file as plain levels and pulses: queue enable, queue clear, trigger select and character length. A character-time tick paces the timeout. A read pulse pops the oldest character, and a separate pulse marks a read of line status, which clears overrun. Serial reception and baud timing are outside this block.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the block is empty: dataReady, overrun, errSummary, trigReq and timeoutReq are 0, and rdData and all top flags read 0.
- R2: With fifoEn=1 the block holds up to DEPTH (16) characters and returns them in arrival order. dataReady is 1 whenever at least one character is stored.
- R3: A character that arrives while the queue is full, with no read in the same cycle, is dropped, the stored characters are kept, and overrun is set. A lsrRead pulse clears overrun. If a drop and lsrRead fall in the same cycle, overrun ends up set.
- R4: A character that arrives in the same cycle as a read of a full queue is accepted. The level stays full and no overrun is raised.
- R5: topParErr, topFrmErr and topBrk are the flags of the oldest stored character. They and rdData read 0 while the block is empty.
- R6: A character that arrives with the break indication is stored with data 0x00 and its framing flag forced to 1, whatever data and framing value came with it.
- R7: With fifoEn=1, errSummary is 1 while at least one stored character has a parity, framing or break flag. It drops once the last such character has been read.
- R8: trigSel picks the trigger level: 00 = 1, 01 = 4, 10 = 8, 11 = 14 characters. trigReq is 1 while the stored count is at or above that level. With fifoEn=0, trigReq equals dataReady.
- R9: With fifoEn=1, timeoutReq rises once TOUT_CHARS (4) charTick pulses have been seen with no accepted arrival and no read, while the count is nonzero and below the trigger level. Any accepted arrival or read restarts the count. The count is held at zero while the queue is empty.
- R10: rdData is the oldest character masked to the length set by wordLen: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8.
- R11: A fifoClr pulse, or any change of fifoEn, empties the block and zeroes the error count. An arrival in that cycle is discarded. Overrun is not affected.
- R12: With fifoEn=0 the block holds one character. An arrival while it is occupied, with no read in the same cycle, replaces that character and sets overrun.
- R13: A read pulse while the block is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | A received character is presented this cycle |
| wrData | input | 8 | Received character bits |
| wrParErr | input | 1 | Parity error for the presented character |
| wrFrmErr | input | 1 | Framing error for the presented character |
| wrBrk | input | 1 | Break received in place of this character |
| fifoEn | input | 1 | 1 = sixteen-deep queue, 0 = single holding word |
| fifoClr | input | 1 | Pulse: discard all stored characters |
| trigSel | input | 2 | Trigger level select |
| wordLen | input | 2 | Character length select for masking |
| charTick | input | 1 | One pulse per character time |
| rdStrobe | input | 1 | Pulse: pop the oldest character |
| lsrRead | input | 1 | Pulse: line status was read (clears overrun) |
| rdData | output | 8 | Oldest character, masked |
| dataReady | output | 1 | At least one character stored |
| overrun | output | 1 | A character was lost |
| topParErr | output | 1 | Parity flag of oldest character |
| topFrmErr | output | 1 | Framing flag of oldest character |
| topBrk | output | 1 | Break flag of oldest character |
| errSummary | output | 1 | Some stored character carries an error |
| trigReq | output | 1 | Stored count at or above trigger level |
| timeoutReq | output | 1 | Character timeout request |

## Verification
Two pairs of events can fall in the same cycle. An arrival can meet a read, and an overrun drop can meet the line-status read that clears overrun. Directed steps fill the queue to sixteen and then apply an arrival together with a read, and a drop together with lsrRead. Each outcome is judged on the level, the read order and the final overrun value. Long random traffic then alternates between reading slowly and reading quickly, so that full and near-full states recur with simultaneous pushes, pops, clears and mode changes. A behavioural queue model in the bench is compared against every output on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // One stored character with its receive flags.
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxWord_t;

  // Per-cycle commands from control to storage.
  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
    logic overwrite;
  } rxStrobe_t;

  function automatic logic [7:0] lenMask(input logic [1:0] wl);
    case (wl)
      2'b00:   lenMask = 8'h1F;
      2'b01:   lenMask = 8'h3F;
      2'b10:   lenMask = 8'h7F;
      default: lenMask = 8'hFF;
    endcase
  endfunction

  function automatic int unsigned trigWords(input logic [1:0] sel);
    case (sel)
      2'b00:   trigWords = 1;
      2'b01:   trigWords = 4;
      2'b10:   trigWords = 8;
      default: trigWords = 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  strb,
  input  rxWord_t    inWord,
  input  logic [1:0] wordLen,
  input  logic       notEmpty,
  output logic       headErr,
  output logic [7:0] rdData,
  output logic       topPar,
  output logic       topFrm,
  output logic       topBrk
);

  localparam int PTR_W = $clog2(DEPTH);

  rxWord_t          slots [DEPTH];
  logic [DEPTH-1:0] slotWe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  rxWord_t          storeWord;
  rxWord_t          headWord;

  // A break is kept as an all-zero character with framing forced.
  always_comb begin
    storeWord = inWord;
    if (inWord.brk) begin
      storeWord.data = '0;
      storeWord.frm  = 1'b1;
    end
  end

  // Write enable per slot: normal append, or replace the head in single mode.
  for (genvar e = 0; e < DEPTH; e++) begin : g_we
    assign slotWe[e] = (strb.push      && (wrPtr == PTR_W'(e))) ||
                       (strb.overwrite && (rdPtr == PTR_W'(e)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) slots[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (slotWe[e]) slots[e] <= storeWord;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign headWord = slots[rdPtr];
  assign headErr  = headWord.par | headWord.frm | headWord.brk;
  assign rdData   = notEmpty ? (headWord.data & lenMask(wordLen)) : 8'h00;
  assign topPar   = notEmpty & headWord.par;
  assign topFrm   = notEmpty & headWord.frm;
  assign topBrk   = notEmpty & headWord.brk;

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TOUT_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       newErr,
  input  logic       headErr,
  input  logic       fifoEn,
  input  logic       fifoClr,
  input  logic [1:0] trigSel,
  input  logic       charTick,
  input  logic       rdStrobe,
  input  logic       lsrRead,
  output rxStrobe_t  strb,
  output logic       notEmpty,
  output logic       overrun,
  output logic       errSummary,
  output logic       trigReq,
  output logic       timeoutReq
);

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int TC_W  = $clog2(TOUT_CHARS + 1);

  logic             fifoEnQ;
  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] levelNext;
  logic [LVL_W-1:0] errCnt;
  logic [LVL_W-1:0] errNext;
  logic [LVL_W-1:0] capWords;
  logic [LVL_W-1:0] trigLevel;
  logic [TC_W-1:0]  toutCnt;
  logic             clearNow;
  logic             isFull;
  logic             dropWord;

  always_comb begin
    clearNow       = fifoClr | (fifoEn ^ fifoEnQ);
    capWords       = fifoEn ? LVL_W'(DEPTH) : LVL_W'(1);
    trigLevel      = LVL_W'(trigWords(trigSel));
    notEmpty       = (level != '0);
    isFull         = (level == capWords);
    strb.clear     = clearNow;
    strb.pop       = rdStrobe & notEmpty & ~clearNow;
    strb.push      = wrValid & ~clearNow & (~isFull | strb.pop);
    dropWord       = wrValid & ~clearNow & isFull & ~strb.pop;
    strb.overwrite = dropWord & ~fifoEn;
  end

  always_comb begin
    levelNext = level + LVL_W'(strb.push) - LVL_W'(strb.pop);
    errNext   = errCnt
              + LVL_W'(strb.push & newErr)
              + LVL_W'(strb.overwrite & newErr)
              - LVL_W'(strb.pop & headErr)
              - LVL_W'(strb.overwrite & headErr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ <= 1'b0;
      level   <= '0;
      errCnt  <= '0;
      overrun <= 1'b0;
      toutCnt <= '0;
    end else begin
      fifoEnQ <= fifoEn;
      if (clearNow) begin
        level  <= '0;
        errCnt <= '0;
      end else begin
        level  <= levelNext;
        errCnt <= errNext;
      end
      if (dropWord)     overrun <= 1'b1;
      else if (lsrRead) overrun <= 1'b0;
      if (clearNow | strb.push | strb.pop | ~notEmpty | ~fifoEn)
        toutCnt <= '0;
      else if (charTick && (toutCnt != TC_W'(TOUT_CHARS)))
        toutCnt <= toutCnt + 1'b1;
    end
  end

  assign errSummary = fifoEn & (errCnt != '0);
  assign trigReq    = fifoEn ? (level >= trigLevel) : notEmpty;
  assign timeoutReq = fifoEn & notEmpty & (level < trigLevel) &
                      (toutCnt == TC_W'(TOUT_CHARS));

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R3
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && isFull && !rdStrobe && !clearNow) |=> (overrun && $stable(level)));

  // R4
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rdStrobe && isFull && !clearNow) |=>
      ((level == $past(level)) && !$rose(overrun)));

  // R7
  err_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= level);

  // R9
  tout_below_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutReq |-> (notEmpty && !trigReq));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> ((level == '0) && (errCnt == '0)));

  // R13
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !notEmpty && !wrValid) |=> !notEmpty);

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TOUT_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrParErr,
  input  logic       wrFrmErr,
  input  logic       wrBrk,
  input  logic       fifoEn,
  input  logic       fifoClr,
  input  logic [1:0] trigSel,
  input  logic [1:0] wordLen,
  input  logic       charTick,
  input  logic       rdStrobe,
  input  logic       lsrRead,
  output logic [7:0] rdData,
  output logic       dataReady,
  output logic       overrun,
  output logic       topParErr,
  output logic       topFrmErr,
  output logic       topBrk,
  output logic       errSummary,
  output logic       trigReq,
  output logic       timeoutReq
);

  rxWord_t   inWord;
  rxStrobe_t strb;
  logic      notEmpty;
  logic      headErr;
  logic      newErr;

  assign inWord = '{brk: wrBrk, frm: wrFrmErr, par: wrParErr, data: wrData};
  assign newErr = wrParErr | wrFrmErr | wrBrk;

  rxq_ctrl #(.DEPTH(DEPTH), .TOUT_CHARS(TOUT_CHARS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .newErr     (newErr),
    .headErr    (headErr),
    .fifoEn     (fifoEn),
    .fifoClr    (fifoClr),
    .trigSel    (trigSel),
    .charTick   (charTick),
    .rdStrobe   (rdStrobe),
    .lsrRead    (lsrRead),
    .strb       (strb),
    .notEmpty   (notEmpty),
    .overrun    (overrun),
    .errSummary (errSummary),
    .trigReq    (trigReq),
    .timeoutReq (timeoutReq)
  );

  rxq_data #(.DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inWord   (inWord),
    .wordLen  (wordLen),
    .notEmpty (notEmpty),
    .headErr  (headErr),
    .rdData   (rdData),
    .topPar   (topParErr),
    .topFrm   (topFrmErr),
    .topBrk   (topBrk)
  );

  assign dataReady = notEmpty;

endmodule

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN;
  logic       wrValid;
  logic [7:0] wrData;
  logic       wrParErr, wrFrmErr, wrBrk;
  logic       fifoEn, fifoClr;
  logic [1:0] trigSel, wordLen;
  logic       charTick, rdStrobe, lsrRead;
  logic [7:0] rdData;
  logic       dataReady, overrun, topParErr, topFrmErr, topBrk;
  logic       errSummary, trigReq, timeoutReq;

  rx_err_fifo #(.DEPTH(16), .TOUT_CHARS(4)) i_rx_err_fifo (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural reference: {brk, frm, par, data}
  typedef logic [10:0] mword_t;
  mword_t q[$];
  bit     mEnQ, mOvr;
  int     mTout;
  int     oldSz, cap, sz, errWords;
  bit     clr, popOk, pushed;
  mword_t w, head;

  function automatic int trigOf(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 14;
  endfunction

  function automatic logic [7:0] maskOf(logic [1:0] wl);
    return (wl == 2'b00) ? 8'h1F : (wl == 2'b01) ? 8'h3F : (wl == 2'b10) ? 8'h7F : 8'hFF;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      mEnQ  = 0;
      mOvr  = 0;
      mTout = 0;
    end else begin
      oldSz  = q.size();
      clr    = fifoClr || (fifoEn != mEnQ);
      cap    = fifoEn ? 16 : 1;
      popOk  = rdStrobe && (oldSz != 0) && !clr;
      pushed = 0;
      w      = wrBrk ? {1'b1, 1'b1, wrParErr, 8'h00} : {1'b0, wrFrmErr, wrParErr, wrData};
      if (lsrRead) mOvr = 0;
      if (clr) q.delete();
      else if (wrValid && (oldSz == cap) && !popOk) begin
        mOvr = 1;
        if (!fifoEn) q[0] = w;
      end else begin
        if (popOk) void'(q.pop_front());
        if (wrValid) begin
          q.push_back(w);
          pushed = 1;
        end
      end
      if (clr || pushed || popOk || (oldSz == 0) || !fifoEn) mTout = 0;
      else if (charTick && (mTout < 4)) mTout++;
      mEnQ = fifoEn;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      sz = q.size();
      head = (sz != 0) ? q[0] : '0;
      errWords = 0;
      foreach (q[k]) if (q[k][10:8] != 3'b000) errWords++;
      chk("R2 dataReady", {7'd0, dataReady}, {7'd0, sz != 0});
      chk("R10 rdData", rdData, (sz != 0) ? (head[7:0] & maskOf(wordLen)) : 8'h00);
      chk("R3 overrun", {7'd0, overrun}, {7'd0, mOvr});
      chk("R5 topParErr", {7'd0, topParErr}, {7'd0, head[8]});
      chk("R5 topFrmErr", {7'd0, topFrmErr}, {7'd0, head[9]});
      chk("R5 topBrk", {7'd0, topBrk}, {7'd0, head[10]});
      chk("R7 errSummary", {7'd0, errSummary}, {7'd0, fifoEn && (errWords > 0)});
      chk("R8 trigReq", {7'd0, trigReq},
          {7'd0, fifoEn ? (sz >= trigOf(trigSel)) : (sz != 0)});
      chk("R9 timeoutReq", {7'd0, timeoutReq},
          {7'd0, fifoEn && (sz != 0) && (sz < trigOf(trigSel)) && (mTout == 4)});
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pushW(logic [7:0] d, logic p, logic f, logic b);
    wrValid = 1; wrData = d; wrParErr = p; wrFrmErr = f; wrBrk = b;
    cyc();
    wrValid = 0; wrParErr = 0; wrFrmErr = 0; wrBrk = 0;
  endtask

  task automatic readW();
    rdStrobe = 1;
    cyc();
    rdStrobe = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; wrValid = 0; wrData = 0; wrParErr = 0; wrFrmErr = 0; wrBrk = 0;
    fifoEn = 0; fifoClr = 0; trigSel = 0; wordLen = 2'b11;
    charTick = 0; rdStrobe = 0; lsrRead = 0;
    cyc(3);
    rstN = 1;
    cyc();
    // R1 reset state
    chk("R1 dataReady", {7'd0, dataReady}, 8'd0);
    chk("R1 overrun", {7'd0, overrun}, 8'd0);
    chk("R1 rdData", rdData, 8'd0);
    chk("R1 trigReq", {7'd0, trigReq}, 8'd0);
    chk("R1 errSummary", {7'd0, errSummary}, 8'd0);

    // Queue mode: fill to sixteen, overrun cases, simultaneous push/pop
    fifoEn = 1; trigSel = 2'b11;
    cyc();
    for (int i = 0; i < 16; i++)
      pushW((i == 5) ? 8'h77 : 8'(i), i == 3, 1'b0, i == 5);
    pushW(8'hEE, 0, 0, 0);
    chk("R3 overrun on full", {7'd0, overrun}, 8'd1);
    chk("R3 head kept", rdData, 8'h00);
    lsrRead = 1; cyc(); lsrRead = 0;
    chk("R3 lsrRead clears", {7'd0, overrun}, 8'd0);
    wrValid = 1; wrData = 8'hEF; lsrRead = 1;
    cyc();
    wrValid = 0; lsrRead = 0;
    chk("R3 set wins over clear", {7'd0, overrun}, 8'd1);
    wrValid = 1; wrData = 8'hAB; rdStrobe = 1;
    cyc();
    wrValid = 0; rdStrobe = 0;
    chk("R4 head after pop", rdData, 8'h01);
    chk("R4 still full trig", {7'd0, trigReq}, 8'd1);
    for (int k = 0; k < 16; k++) begin
      if (k == 15) chk("R4 accepted word last", rdData, 8'hAB);
      else chk("R2 order", rdData, (k + 1 == 5) ? 8'h00 : 8'(k + 1));
      if (k == 2) begin
        chk("R5 head parity", {7'd0, topParErr}, 8'd1);
        chk("R7 summary set", {7'd0, errSummary}, 8'd1);
      end
      if (k == 4) begin
        chk("R6 break flag", {7'd0, topBrk}, 8'd1);
        chk("R6 framing forced", {7'd0, topFrmErr}, 8'd1);
      end
      if (k == 5) chk("R7 summary cleared", {7'd0, errSummary}, 8'd0);
      readW();
    end
    chk("R2 empty after drain", {7'd0, dataReady}, 8'd0);
    lsrRead = 1; cyc(); lsrRead = 0;

    // Timeout and trigger level
    trigSel = 2'b01;
    pushW(8'h10, 0, 0, 0);
    pushW(8'h11, 0, 0, 0);
    charTick = 1;
    cyc(3);
    chk("R9 no timeout at 3", {7'd0, timeoutReq}, 8'd0);
    cyc();
    chk("R9 timeout at 4", {7'd0, timeoutReq}, 8'd1);
    charTick = 0;
    readW();
    chk("R9 read restarts", {7'd0, timeoutReq}, 8'd0);
    pushW(8'h12, 0, 0, 0);
    pushW(8'h13, 0, 0, 0);
    pushW(8'h14, 0, 0, 0);
    chk("R8 trigger at 4", {7'd0, trigReq}, 8'd1);
    charTick = 1; cyc(5); charTick = 0;
    chk("R9 none at trigger", {7'd0, timeoutReq}, 8'd0);
    fifoClr = 1; cyc(); fifoClr = 0;
    chk("R11 clear empties", {7'd0, dataReady}, 8'd0);

    // Length masking
    pushW(8'hFF, 0, 0, 0);
    for (int wl = 0; wl < 4; wl++) begin
      wordLen = 2'(wl);
      #1;
      chk("R10 mask", rdData, maskOf(2'(wl)));
    end
    wordLen = 2'b11;
    readW();

    // Read while empty
    readW();
    chk("R13 empty read", {7'd0, dataReady}, 8'd0);
    pushW(8'h5A, 0, 0, 0);
    chk("R13 next word intact", rdData, 8'h5A);
    readW();

    // Single holding word mode
    fifoEn = 0; cyc();
    pushW(8'h11, 0, 0, 0);
    pushW(8'h22, 0, 0, 0);
    chk("R12 replaced word", rdData, 8'h22);
    chk("R12 overrun", {7'd0, overrun}, 8'd1);
    lsrRead = 1; cyc(); lsrRead = 0;
    fifoEn = 1; cyc();
    chk("R11 mode change empties", {7'd0, dataReady}, 8'd0);

    // Random traffic with alternating read pressure
    for (int n = 0; n < 6000; n++) begin
      wrValid  = ($urandom % 2) == 0;
      wrData   = 8'($urandom);
      wrParErr = ($urandom % 8) == 0;
      wrFrmErr = ($urandom % 10) == 0;
      wrBrk    = ($urandom % 16) == 0;
      rdStrobe = (((n / 400) % 2) == 0) ? (($urandom % 10) == 0) : (($urandom % 10) < 6);
      lsrRead  = ($urandom % 8) == 0;
      charTick = ($urandom % 3) == 0;
      fifoClr  = ($urandom % 300) == 0;
      if (($urandom % 700) == 0) fifoEn = ~fifoEn;
      if (($urandom % 50) == 0) trigSel = 2'($urandom);
      if (($urandom % 50) == 0) wordLen = 2'($urandom);
      cyc();
    end
    wrValid = 0; rdStrobe = 0; lsrRead = 0; charTick = 0; fifoClr = 0;
    wrParErr = 0; wrFrmErr = 0; wrBrk = 0;
    cyc(2);
    finished = 1;
    summary();
    $finish;
  end

endmodule